// File: doc/BRIEF.md
# Load Result Shaper with Branch-on-Load

This block sits at the end of a load path. It takes the raw data word returned from memory along with the access size, a signedness flag and the low two address bits. It produces the value that goes into the destination register. Byte and halfword loads pick their lane from the word in little-endian order. The lane is then zero-extended or sign-extended to the full register width.

When a load names the program counter as its destination, the block does not write a register. A word load into the program counter becomes a branch request instead. The request carries the loaded address with bit 0 cleared, plus an instruction-state select taken from bit 0 of the loaded value. An architecture-mode input chooses between two target checks:
- The older mode accepts only targets that are 4-byte aligned.
- The newer mode rejects the low-bit pattern `2'b10` and treats bit 0 as the state select.

Illegal cases raise a fault flag in place of the write or the branch. All outputs are registered, so they appear one cycle after the request.

Top module: `ld_result_shaper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rd_we`, `br_valid`, `br_compact` and `fault` are 0, and `rd_data` and `br_target` are zero.
- R2: A byte load (`ld_size`=0) with `ld_signed`=0 and a register destination returns data byte number `ld_addr_lo` (byte 0 = bits 7:0), zero-extended to 32 bits, with `rd_we`=1.
- R3: A signed byte load (`ld_size`=0, `ld_signed`=1) returns the selected byte sign-extended from its bit 7.
- R4: A halfword load (`ld_size`=1) returns the halfword selected by `ld_addr_lo[1]` (0 = bits 15:0, 1 = bits 31:16). The result is zero-extended when `ld_signed`=0 and sign-extended from bit 15 when `ld_signed`=1. `ld_addr_lo[0]` is ignored.
- R5: A word load (`ld_size`=2) with a register destination returns the data word unchanged, whatever `ld_addr_lo` and `ld_signed` are.
- R6: Results appear exactly one clock after the request is sampled. A cycle with `ld_valid`=0 gives all flags 0 and both data outputs 0 in the following cycle.
- R7: A byte or halfword load with `ld_to_pc`=1 gives `fault`=1 and no write or branch.
- R8: In the newer mode (`arch_new`=1), a word load into the PC whose loaded bits [1:0] are `2'b10` gives `fault`=1 and no branch.
- R9: In the newer mode, any other word load into the PC gives `br_valid`=1 and `br_target` = loaded value with bit 0 cleared. It also gives `br_compact` = loaded bit 0 (1 = compact state, 0 = full state).
- R10: In the older mode (`arch_new`=0), a word load into the PC branches to the loaded value with `br_compact`=0 only when loaded bits [1:0] are `2'b00`. Any other value gives `fault`=1 and no branch.
- R11: At most one of `rd_we`, `br_valid` and `fault` is 1 in any cycle. `rd_data` is zero unless `rd_we`=1. `br_target` and `br_compact` are zero unless `br_valid`=1.
- R12: The reserved size code `ld_size`=3 gives `fault`=1 for either destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load result is present this cycle |
| ld_data | input | 32 | Raw word returned from memory |
| ld_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| ld_signed | input | 1 | Sign-extend a byte or halfword |
| ld_addr_lo | input | 2 | Low address bits of the access |
| ld_to_pc | input | 1 | Destination is the program counter |
| arch_new | input | 1 | 1 newer target rules, 0 older target rules |
| rd_data | output | 32 | Value for the destination register |
| rd_we | output | 1 | Register write enable |
| br_valid | output | 1 | Branch request |
| br_target | output | 32 | Branch address, bit 0 cleared |
| br_compact | output | 1 | 1 compact state, 0 full state |
| fault | output | 1 | Illegal load result |

## Verification
A word load into the program counter can both request a branch and be rejected by the target check in the same cycle. This happens with loaded bits `2'b10` in the newer mode, or any non-zero low bits in the older mode. In that case the fault must win and the branch must be suppressed.

The bench provokes this by sweeping data patterns that cover all four low-bit values against both modes and both destinations. Each result is compared against an arithmetic model. The three output flags are also checked to show at most one set.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } ld_size_e;

endpackage

// File: rtl/ldfmt_lane_extract.sv
module ldfmt_lane_extract #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]              raw,
    input  ldfmt_pkg::ld_size_e          size,
    input  logic                         sext,
    input  logic [$clog2(XLEN/8)-1:0]    lane,
    output logic [XLEN-1:0]              value
);
    localparam int NB = XLEN / 8;
    localparam int NH = NB / 2;
    localparam int LW = $clog2(NB);

    logic [7:0]  byte_arr [NB];
    logic [15:0] half_arr [NH];
    logic [7:0]  b_sel;
    logic [15:0] h_sel;

    // Little-endian lane split: lane 0 holds the least significant bits.
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign byte_arr[i] = raw[8*i +: 8];
    end
    for (genvar j = 0; j < NH; j++) begin : g_half
        assign half_arr[j] = raw[16*j +: 16];
    end

    always_comb begin
        b_sel = byte_arr[lane];
        h_sel = half_arr[lane[LW-1:1]];
        case (size)
            ldfmt_pkg::SZ_BYTE: value = {{(XLEN-8){sext & b_sel[7]}}, b_sel};
            ldfmt_pkg::SZ_HALF: value = {{(XLEN-16){sext & h_sel[15]}}, h_sel};
            default:            value = raw;
        endcase
    end
endmodule

// File: rtl/ldfmt_pc_target.sv
module ldfmt_pc_target #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] raw,
    input  logic            arch_new,
    output logic [XLEN-1:0] target,
    output logic            compact,
    output logic            misaligned
);
    always_comb begin
        target = {raw[XLEN-1:1], 1'b0};
        if (arch_new) begin
            // Newer rules: bit 0 carries the state, pattern 2'b10 is illegal.
            misaligned = (raw[1:0] == 2'b10);
            compact    = raw[0];
        end else begin
            // Older rules: the target must be word aligned, state never changes.
            misaligned = (raw[1:0] != 2'b00);
            compact    = 1'b0;
        end
    end
endmodule

// File: rtl/ld_result_shaper.sv
module ld_result_shaper #(
    parameter int XLEN = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_valid,
    input  logic [XLEN-1:0]           ld_data,
    input  logic [1:0]                ld_size,
    input  logic                      ld_signed,
    input  logic [$clog2(XLEN/8)-1:0] ld_addr_lo,
    input  logic                      ld_to_pc,
    input  logic                      arch_new,
    output logic [XLEN-1:0]           rd_data,
    output logic                      rd_we,
    output logic                      br_valid,
    output logic [XLEN-1:0]           br_target,
    output logic                      br_compact,
    output logic                      fault
);
    import ldfmt_pkg::*;

    typedef struct packed {
        logic [XLEN-1:0] rd;
        logic            we;
        logic            br;
        logic [XLEN-1:0] tgt;
        logic            compact;
        logic            fault;
    } out_t;

    out_t     out_d, out_q;
    ld_size_e size_e;

    logic [XLEN-1:0] ext_value;
    logic [XLEN-1:0] pc_tgt;
    logic            pc_compact;
    logic            pc_bad;

    assign size_e = ld_size_e'(ld_size);

    ldfmt_lane_extract #(.XLEN(XLEN)) u_lane (
        .raw   (ld_data),
        .size  (size_e),
        .sext  (ld_signed),
        .lane  (ld_addr_lo),
        .value (ext_value)
    );

    ldfmt_pc_target #(.XLEN(XLEN)) u_pct (
        .raw        (ld_data),
        .arch_new   (arch_new),
        .target     (pc_tgt),
        .compact    (pc_compact),
        .misaligned (pc_bad)
    );

    always_comb begin
        out_d = '0;
        if (ld_valid) begin
            if (size_e == SZ_RSVD) begin
                out_d.fault = 1'b1;
            end else if (ld_to_pc) begin
                if (size_e != SZ_WORD || pc_bad) begin
                    out_d.fault = 1'b1;
                end else begin
                    out_d.br      = 1'b1;
                    out_d.tgt     = pc_tgt;
                    out_d.compact = pc_compact;
                end
            end else begin
                out_d.we = 1'b1;
                out_d.rd = ext_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data    = out_q.rd;
    assign rd_we      = out_q.we;
    assign br_valid   = out_q.br;
    assign br_target  = out_q.tgt;
    assign br_compact = out_q.compact;
    assign fault      = out_q.fault;
endmodule

// File: rtl/ldfmt_chk.sv
module ldfmt_chk #(
    parameter int XLEN = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ld_valid,
    input logic [XLEN-1:0]           ld_data,
    input logic [1:0]                ld_size,
    input logic                      ld_signed,
    input logic [$clog2(XLEN/8)-1:0] ld_addr_lo,
    input logic                      ld_to_pc,
    input logic                      arch_new,
    input logic [XLEN-1:0]           rd_data,
    input logic                      rd_we,
    input logic                      br_valid,
    input logic [XLEN-1:0]           br_target,
    input logic                      br_compact,
    input logic                      fault
);
    logic pc_word;
    assign pc_word = ld_valid && ld_to_pc && (ld_size == 2'd2);

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_we, br_valid, fault}) <= 1);

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !(rd_we || br_valid || fault));

    assert_narrow_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_to_pc && ld_size < 2'd2) |=> fault);

    assert_bad_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_word && arch_new && ld_data[1:0] == 2'b10) |=> (fault && !br_valid));

    assert_compact_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_word && arch_new && ld_data[1:0] == 2'b01) |=> (br_valid && br_compact && !br_target[0]));

    assert_old_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_word && !arch_new && ld_data[1:0] != 2'b00) |=> fault);

    assert_old_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_word && !arch_new && ld_data[1:0] == 2'b00) |=> (br_valid && !br_compact));

    assert_zext_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_to_pc && ld_size == 2'd0 && !ld_signed) |=> (rd_we && rd_data[XLEN-1:8] == '0));

    assert_rsvd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_size == 2'd3) |=> fault);

    assert_signed_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_to_pc && ld_size == 2'd2) |=> (rd_data == $past(ld_data)));
endmodule

bind ld_result_shaper ldfmt_chk #(.XLEN(XLEN)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data),
    .ld_size    (ld_size),
    .ld_signed  (ld_signed),
    .ld_addr_lo (ld_addr_lo),
    .ld_to_pc   (ld_to_pc),
    .arch_new   (arch_new),
    .rd_data    (rd_data),
    .rd_we      (rd_we),
    .br_valid   (br_valid),
    .br_target  (br_target),
    .br_compact (br_compact),
    .fault      (fault)
);

// File: tb/ld_result_shaper_tb_top.sv
module ld_result_shaper_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic [1:0]  ld_size;
    logic        ld_signed;
    logic [1:0]  ld_addr_lo;
    logic        ld_to_pc;
    logic        arch_new;
    logic [31:0] rd_data;
    logic        rd_we;
    logic        br_valid;
    logic [31:0] br_target;
    logic        br_compact;
    logic        fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ld_result_shaper #(.XLEN(32)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid   (ld_valid),
        .ld_data    (ld_data),
        .ld_size    (ld_size),
        .ld_signed  (ld_signed),
        .ld_addr_lo (ld_addr_lo),
        .ld_to_pc   (ld_to_pc),
        .arch_new   (arch_new),
        .rd_data    (rd_data),
        .rd_we      (rd_we),
        .br_valid   (br_valid),
        .br_target  (br_target),
        .br_compact (br_compact),
        .fault      (fault)
    );

    function automatic logic [31:0] pattern(input int k);
        case (k)
            0: pattern = 32'h80FF_7F01;
            1: pattern = 32'h7F80_01FE;
            2: pattern = 32'hFFFF_FFFF;
            3: pattern = 32'h0000_0000;
            4: pattern = 32'h1234_5678;
            5: pattern = 32'h8001_8002;
            6: pattern = 32'hA5A5_5A5B;
            default: pattern = 32'h4000_0001;
        endcase
    endfunction

    // Packed view: {we, br, fault, compact, rd[31:0], tgt[31:0]}
    function automatic logic [67:0] model(input logic v, input logic [31:0] d, input logic [1:0] sz,
                                          input logic sg, input logic [1:0] a, input logic pc,
                                          input logic an);
        logic [31:0] r;
        logic [31:0] lane;
        model = '0;
        if (!v) return model;
        if (sz == 2'd3) begin
            model[65] = 1'b1;
        end else if (pc) begin
            if (sz != 2'd2) model[65] = 1'b1;
            else if (an && d[1:0] == 2'b10) model[65] = 1'b1;
            else if (!an && d[1:0] != 2'b00) model[65] = 1'b1;
            else begin
                model[66] = 1'b1;
                model[64] = an ? d[0] : 1'b0;
                model[31:0] = d - {31'd0, d[0]};
            end
        end else begin
            if (sz == 2'd0) begin
                lane = (d >> (8 * a)) & 32'hFF;
                r = (sg && lane[7]) ? (lane | 32'hFFFF_FF00) : lane;
            end else if (sz == 2'd1) begin
                lane = (d >> (16 * a[1])) & 32'hFFFF;
                r = (sg && lane[15]) ? (lane | 32'hFFFF_0000) : lane;
            end else begin
                r = d;
            end
            model[67] = 1'b1;
            model[63:32] = r;
        end
    endfunction

    task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h (size=%0d sgn=%0d addr=%0d pc=%0d new=%0d data=%h)",
                     tag, act, exp, ld_size, ld_signed, ld_addr_lo, ld_to_pc, arch_new, ld_data);
        end
    endtask

    function automatic string tag_of(input logic v, input logic [1:0] sz, input logic sg,
                                     input logic pc, input logic an);
        if (!v) return "R6";
        if (sz == 2'd3) return "R12";
        if (pc && sz != 2'd2) return "R7";
        if (pc && an) return "R8 R9";
        if (pc) return "R10";
        if (sz == 2'd0) return sg ? "R3" : "R2";
        if (sz == 2'd1) return "R4";
        return "R5";
    endfunction

    function automatic logic [67:0] observed();
        return {rd_we, br_valid, fault, br_compact, rd_data, br_target};
    endfunction

    task automatic run_one(input logic v, input logic [31:0] d, input logic [1:0] sz, input logic sg,
                           input logic [1:0] a, input logic pc, input logic an);
        logic [67:0] exp;
        ld_valid = v; ld_data = d; ld_size = sz; ld_signed = sg;
        ld_addr_lo = a; ld_to_pc = pc; arch_new = an;
        exp = model(v, d, sz, sg, a, pc, an);
        @(negedge clk);
        check(tag_of(v, sz, sg, pc, an), observed(), exp);
        // R11: flags mutually exclusive, data fields clean when their flag is low
        n_checks++;
        if ($countones({rd_we, br_valid, fault}) > 1 || (!rd_we && rd_data != 0) ||
            (!br_valid && (br_target != 0 || br_compact))) begin
            n_fails++;
            $display("FAIL R11: flags we=%0d br=%0d fault=%0d expected at most one", rd_we, br_valid, fault);
        end
    endtask

    initial begin
        rst_n = 1'b0; ld_valid = 1'b1; ld_data = 32'hFFFF_FFFF; ld_size = 2'd0;
        ld_signed = 1'b1; ld_addr_lo = 2'd0; ld_to_pc = 1'b0; arch_new = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", observed(), 68'd0);
        ld_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", observed(), 68'd0);
        for (int k = 0; k < 8; k++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    for (int a = 0; a < 4; a++) begin
                        for (int pc = 0; pc < 2; pc++) begin
                            for (int an = 0; an < 2; an++) begin
                                run_one(1'b1, pattern(k), 2'(sz), 1'(sg), 2'(a), 1'(pc), 1'(an));
                                if (a == 0 && sg == 0)
                                    run_one(1'b0, pattern(k), 2'(sz), 1'(sg), 2'(a), 1'(pc), 1'(an));
                            end
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule